// File: doc/BRIEF.md
# Ethernet Frame Check Sequence Generator and Checker

This block sits in a byte-wide receive or transmit path and handles the 32-bit frame check sequence of Ethernet frames. It takes a byte stream that still carries the line preamble and watches for the run of `0x55` bytes and the `0xD5` start delimiter. It drops those bytes and passes every following byte unchanged to its output stream. While the bytes pass, it folds each one into a CRC-32 register in one clock.

The block has two modes, chosen per frame by `check_mode`; the pin is sampled when the delimiter is accepted. In generate mode, the last body byte is followed on the output by four FCS bytes, with `in_ready` held low while they go out. In check mode, the incoming frame already ends with its FCS. Nothing is appended, and the block reports whether the register finished on the fixed CRC-32 residue.

Both byte streams use valid/ready handshakes. A byte moves on a clock edge where valid and ready are both high. A sender must hold valid, data and last steady until its byte is taken. While a body byte is presented, `in_ready` follows `out_ready` in the same cycle, so a stall on the output stalls the input with no buffering in between. During the FCS tail, `in_ready` is low and the tail byte is held until `out_ready` takes it.

Top module: `eth_fcs_gen`

## Requirements
- R1: While reset is asserted and directly after it is released, `out_valid`, `done`, `fcs_good` and `fcs_value` are zero and `in_ready` is high.
- R2: A frame starts only when at least seven consecutive `0x55` bytes are followed by a `0xD5` byte. None of these bytes appears on the output stream (`out_valid` stays low while they are accepted).
- R3: A delimiter preceded by fewer than seven `0x55` bytes does not start a frame, and the bytes after it are not forwarded.
- R4: A byte with `in_last` high accepted before a frame has started ends the hunt. The preamble count restarts from zero, and no FCS or `done` is produced.
- R5: Each body byte appears on `out_data` with `out_valid` high in the cycle it is presented. In generate mode `out_last` is low for all body bytes.
- R6: The CRC uses the reflected polynomial `0xEDB88320` (powers 32,26,23,22,16,12,11,10,8,7,5,4,2,1,0). The register is preset to all ones at the delimiter, and each byte is taken bit 0 first. The FCS is the inverted register; for the ASCII body `123456789` it is `0xCBF43926`.
- R7: In generate mode the four FCS bytes follow the last body byte, bits [7:0] first and bits [31:24] last, with `out_last` on the fourth only. `in_ready` is low throughout the tail.
- R8: While `out_ready` is low, `in_ready` is low during the body. A pending output byte stays valid and unchanged until it is taken.
- R9: `done` is a one-cycle pulse in the cycle after the handshake of the frame's final output byte. `fcs_value` then holds the inverted final register.
- R10: In check mode no bytes are appended and `out_last` follows `in_last`. At `done`, `fcs_good` is high exactly when the register after the last byte equals `0xDEBB20E3`, and `fcs_value` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| check_mode | input | 1 | 0 = append FCS, 1 = verify trailing FCS; sampled at the delimiter |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the last of its frame |
| in_ready | output | 1 | Block takes the input byte this cycle |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte ends the frame |
| out_ready | input | 1 | Downstream takes the output byte |
| done | output | 1 | One-cycle end-of-frame pulse |
| fcs_value | output | 32 | FCS of the last completed frame |
| fcs_good | output | 1 | Residue match of the last checked frame |

## Verification
Body bytes reach the output in the same cycle they are presented, with no register in the path. The bench therefore compares `out_data` against the byte it has just driven, one time step after the falling edge and before the accepting rising edge. The FCS bytes start in the cycle after the last body byte is accepted. Each tail byte is sampled in a cycle where the bench holds `out_ready` high, before the edge that takes it.

`done`, `fcs_value` and `fcs_good` are registered and change on the edge of the final handshake. The bench reads them at the next falling edge, in the single cycle the pulse is high. Expected FCS values come from a bit-serial reference model in the bench, and the standard nine-digit test string anchors that model.

// File: rtl/eth_fcs_pkg.sv
package eth_fcs_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_BODY = 2'd1,
    ST_TAIL = 2'd2
  } fcs_state_e;
endpackage

// File: rtl/crc32_byte_step.sv
// One clock's worth of CRC update: DATA_W bits folded in, bit 0 first,
// unrolled into a chain of shift/xor stages that synthesizes to a flat
// XOR network.
module crc32_byte_step #(
  parameter int          CRC_W  = 32,
  parameter int          DATA_W = 8,
  parameter logic [31:0] POLY   = 32'hEDB88320
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [CRC_W-1:0]  crc_out
);
  localparam logic [CRC_W-1:0] POLY_W = CRC_W'(POLY);

  logic [CRC_W-1:0] stage [DATA_W+1];

  assign stage[0] = crc_in;

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    logic fb;
    assign fb           = stage[g][0] ^ data_in[g];
    assign stage[g+1]   = (stage[g] >> 1) ^ ({CRC_W{fb}} & POLY_W);
  end

  assign crc_out = stage[DATA_W];
endmodule

// File: rtl/frame_delim_hunter.sv
// Counts consecutive preamble bytes (saturating) and flags the delimiter
// that opens a frame.
module frame_delim_hunter #(
  parameter int              BYTE_W   = 8,
  parameter int              PRE_LEN  = 7,
  parameter logic [BYTE_W-1:0] PRE_BYTE = 8'h55,
  parameter logic [BYTE_W-1:0] SFD_BYTE = 8'hD5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              beat,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              last_in,
  output logic              sfd_hit
);
  localparam int               CNT_W = $clog2(PRE_LEN + 1);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(PRE_LEN);

  logic [CNT_W-1:0] run_q;

  assign sfd_hit = beat && !last_in && (byte_in == SFD_BYTE) && (run_q == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!active || (beat && (last_in || sfd_hit))) begin
      run_q <= '0;
    end else if (beat) begin
      if (byte_in == PRE_BYTE)
        run_q <= (run_q == FULL) ? run_q : run_q + 1'b1;
      else
        run_q <= '0;
    end
  end
endmodule

// File: rtl/fcs_tail_mux.sv
// Picks the inverted CRC lane to send, lowest lane first.
module fcs_tail_mux #(
  parameter int CRC_W  = 32,
  parameter int BYTE_W = 8,
  localparam int NB    = CRC_W / BYTE_W,
  localparam int IDX_W = $clog2(NB)
) (
  input  logic [CRC_W-1:0]  crc_reg,
  input  logic [IDX_W-1:0]  idx,
  output logic [BYTE_W-1:0] byte_out,
  output logic              is_final
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);

  logic [BYTE_W-1:0] lanes [NB];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lanes[g] = ~crc_reg[g*BYTE_W +: BYTE_W];
  end

  assign byte_out = lanes[idx];
  assign is_final = (idx == LAST_IDX);
endmodule

// File: rtl/eth_fcs_gen.sv
module eth_fcs_gen
  import eth_fcs_pkg::*;
#(
  parameter int                BYTE_W   = 8,
  parameter int                CRC_W    = 32,
  parameter logic [31:0]       POLY     = 32'hEDB88320,
  parameter logic [31:0]       RESIDUE  = 32'hDEBB20E3,
  parameter int                PRE_LEN  = 7,
  parameter logic [BYTE_W-1:0] PRE_BYTE = 8'h55,
  parameter logic [BYTE_W-1:0] SFD_BYTE = 8'hD5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              check_mode,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  input  logic              out_ready,
  output logic              done,
  output logic [CRC_W-1:0]  fcs_value,
  output logic              fcs_good
);
  localparam int               NB    = CRC_W / BYTE_W;
  localparam int               IDX_W = $clog2(NB);
  localparam logic [CRC_W-1:0] RES_W = CRC_W'(RESIDUE);

  fcs_state_e        state;
  logic              mode_q;
  logic [CRC_W-1:0]  crc_q;
  logic [CRC_W-1:0]  crc_nxt;
  logic [IDX_W-1:0]  idx_q;
  logic              done_q;
  logic [CRC_W-1:0]  fcs_q;
  logic              good_q;

  logic              in_fire;
  logic              hunt_beat;
  logic              body_fire;
  logic              tail_fire;
  logic              sfd_hit;
  logic [BYTE_W-1:0] tail_byte;
  logic              tail_final;

  crc32_byte_step #(
    .CRC_W (CRC_W),
    .DATA_W(BYTE_W),
    .POLY  (POLY)
  ) u_step (
    .crc_in (crc_q),
    .data_in(in_data),
    .crc_out(crc_nxt)
  );

  frame_delim_hunter #(
    .BYTE_W  (BYTE_W),
    .PRE_LEN (PRE_LEN),
    .PRE_BYTE(PRE_BYTE),
    .SFD_BYTE(SFD_BYTE)
  ) u_hunt (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (state == ST_HUNT),
    .beat   (hunt_beat),
    .byte_in(in_data),
    .last_in(in_last),
    .sfd_hit(sfd_hit)
  );

  fcs_tail_mux #(
    .CRC_W (CRC_W),
    .BYTE_W(BYTE_W)
  ) u_tail (
    .crc_reg (crc_q),
    .idx     (idx_q),
    .byte_out(tail_byte),
    .is_final(tail_final)
  );

  // Stream handshake: body bytes pass straight through, tail bytes come
  // from the register.
  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_last  = 1'b0;
    out_data  = in_data;
    unique case (state)
      ST_HUNT: begin
        in_ready = 1'b1;
      end
      ST_BODY: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_last  = mode_q & in_last;
      end
      ST_TAIL: begin
        out_valid = 1'b1;
        out_data  = tail_byte;
        out_last  = tail_final;
      end
      default: begin
        in_ready = 1'b0;
      end
    endcase
  end

  assign in_fire   = in_valid && in_ready;
  assign hunt_beat = (state == ST_HUNT) && in_fire;
  assign body_fire = (state == ST_BODY) && in_fire;
  assign tail_fire = (state == ST_TAIL) && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_HUNT;
      mode_q <= 1'b0;
      crc_q  <= '1;
      idx_q  <= '0;
      done_q <= 1'b0;
      fcs_q  <= '0;
      good_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_HUNT: begin
          if (sfd_hit) begin
            state  <= ST_BODY;
            crc_q  <= '1;
            mode_q <= check_mode;
          end
        end
        ST_BODY: begin
          if (body_fire) begin
            crc_q <= crc_nxt;
            if (in_last) begin
              if (mode_q) begin
                done_q <= 1'b1;
                fcs_q  <= ~crc_nxt;
                good_q <= (crc_nxt == RES_W);
                state  <= ST_HUNT;
              end else begin
                idx_q <= '0;
                state <= ST_TAIL;
              end
            end
          end
        end
        ST_TAIL: begin
          if (tail_fire) begin
            if (tail_final) begin
              done_q <= 1'b1;
              fcs_q  <= ~crc_q;
              state  <= ST_HUNT;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  assign done      = done_q;
  assign fcs_value = fcs_q;
  assign fcs_good  = good_q;
endmodule

// File: rtl/eth_fcs_gen_chk.sv
module eth_fcs_gen_chk
  import eth_fcs_pkg::*;
#(
  parameter int                BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] SFD_BYTE = 8'hD5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [BYTE_W-1:0] in_data,
  input logic              in_ready,
  input logic              out_valid,
  input logic [BYTE_W-1:0] out_data,
  input logic              out_last,
  input logic              out_ready,
  input logic              done,
  input fcs_state_e        state,
  input logic              mode_q
);
  AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HUNT) |-> !out_valid); // R2

  AST_SFD_OPENS_BODY: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_BODY) && ($past(state) == ST_HUNT)) |-> $past(in_valid && (in_data == SFD_BYTE))); // R2

  AST_TAIL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAIL) |-> (!in_ready && out_valid)); // R7

  AST_STALL_HOLDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready && out_last)); // R9

  AST_CHECK_NO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && (state == ST_BODY)) |=> (state != ST_TAIL)); // R10
endmodule

bind eth_fcs_gen eth_fcs_gen_chk #(
  .BYTE_W  (BYTE_W),
  .SFD_BYTE(SFD_BYTE)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_data  (in_data),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_data (out_data),
  .out_last (out_last),
  .out_ready(out_ready),
  .done     (done),
  .state    (state),
  .mode_q   (mode_q)
);

// File: tb/eth_fcs_gen_tb_top.sv
module eth_fcs_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  // [31] check mode, [30] corrupt one bit, [29] output stalls,
  // [15:8] payload length, [7:0] payload seed
  localparam logic [31:0] VECS [6] = '{
    32'h0000_0140,
    32'h2000_1007,
    32'h0000_4033,
    32'h8000_0C11,
    32'hC000_0C11,
    32'hA000_2099
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        check_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_last;
  logic        out_ready = 1'b1;
  logic        done;
  logic [31:0] fcs_value;
  logic        fcs_good;

  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc = 0;
  int   frame_err = 0;
  int   tail_err = 0;
  bit   stall_en = 1'b0;
  logic [7:0] body [256];

  eth_fcs_gen dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .check_mode(check_mode),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_ready (out_ready),
    .done      (done),
    .fcs_value (fcs_value),
    .fcs_good  (fcs_good)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Bit-serial reference: preset ones, bit 0 first, reflected polynomial, inverted result.
  function automatic logic [31:0] ref_fcs(input int n);
    logic [31:0] r = '1;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = r[0] ^ body[i][b];
        r  = r >> 1;
        if (fb) r = r ^ 32'hEDB88320;
      end
    end
    return ~r;
  endfunction

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic put_byte(input logic [7:0] b, input logic lst, input bit expect_out, input bit cm);
    in_valid = 1'b1;
    in_data  = b;
    in_last  = lst;
    forever begin
      out_ready = !(stall_en && (cyc % 3 == 1));
      #1;
      if (expect_out) begin
        if (!(out_valid && out_data == b && out_last == (lst && cm))) frame_err++;
        if (!out_ready && in_ready) frame_err++;
      end else begin
        if (out_valid || done) frame_err++;
      end
      if (in_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic collect_tail(output logic [31:0] got);
    got = '0;
    for (int k = 0; k < 4; k++) begin
      forever begin
        out_ready = !(stall_en && (cyc % 3 == 1));
        #1;
        if (!out_valid || in_ready) tail_err++;
        if (out_ready) begin
          got[k*8 +: 8] = out_data;
          if (out_last != (k == 3)) tail_err++;
          break;
        end
        @(negedge clk);
      end
      @(negedge clk);
    end
  endtask

  task automatic run_frame(input int npre, input int n, input bit cm, input bit st,
                           input logic [31:0] exp_fcs, input bit exp_good);
    logic [31:0] got;
    frame_err  = 0;
    tail_err   = 0;
    check_mode = cm;
    stall_en   = st;
    for (int i = 0; i < npre; i++) put_byte(8'h55, 1'b0, 1'b0, cm);
    put_byte(8'hD5, 1'b0, 1'b0, cm);
    for (int i = 0; i < n; i++) put_byte(body[i], (i == n - 1), 1'b1, cm);
    if (!cm) begin
      collect_tail(got);
      chk(got == exp_fcs, "R6 appended FCS bytes", got, exp_fcs);
      chk(tail_err == 0, "R7 tail order, out_last and in_ready", tail_err, 0);
      #1;
      chk(done == 1'b1, "R9 done pulse after final tail byte", {31'd0, done}, 1);
      chk(fcs_value == exp_fcs, "R9 fcs_value at done", fcs_value, exp_fcs);
    end else begin
      #1;
      chk(done == 1'b1, "R10 done after checked frame", {31'd0, done}, 1);
      chk(fcs_good == exp_good, "R10 residue verdict", {31'd0, fcs_good}, {31'd0, exp_good});
      chk(fcs_value == exp_fcs, "R10 fcs_value of checked frame", fcs_value, exp_fcs);
    end
    chk(frame_err == 0, "R5 R8 body forwarding and stall", frame_err, 0);
    @(negedge clk);
    out_ready = 1'b1;
    stall_en  = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=<150000 cycles", cyc);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] f;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0 && done == 1'b0, "R1 outputs idle in reset", {30'd0, out_valid, done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R1 in_ready after reset", {31'd0, in_ready}, 1);
    chk(fcs_value == 32'd0 && fcs_good == 1'b0, "R1 result registers cleared", fcs_value, 0);
    @(negedge clk);

    // Vector table
    for (int v = 0; v < 6; v++) begin
      bit cm, cor, st;
      int len;
      cm  = VECS[v][31];
      cor = VECS[v][30];
      st  = VECS[v][29];
      len = int'(VECS[v][15:8]);
      for (int k = 0; k < len; k++) body[k] = VECS[v][7:0] ^ 8'(k * 37);
      if (!cm) begin
        run_frame(7, len, 1'b0, st, ref_fcs(len), 1'b0);
      end else begin
        f = ref_fcs(len);
        for (int k = 0; k < 4; k++) body[len + k] = f[k*8 +: 8];
        if (cor) body[0] = body[0] ^ 8'h01;
        run_frame(7, len + 4, 1'b1, st, ref_fcs(len + 4), !cor);
      end
    end

    // Standard check string, generate then verify (R6, R10)
    for (int k = 0; k < 9; k++) body[k] = 8'h31 + 8'(k);
    run_frame(7, 9, 1'b0, 1'b0, 32'hCBF43926, 1'b0);
    body[9] = 8'h26; body[10] = 8'h39; body[11] = 8'hF4; body[12] = 8'hCB;
    run_frame(7, 13, 1'b1, 1'b0, 32'h2144DF1C, 1'b1);
    held = fcs_value;

    // R3: short preamble does not open a frame
    frame_err = 0;
    check_mode = 1'b0;
    for (int i = 0; i < 5; i++) put_byte(8'h55, 1'b0, 1'b0, 1'b0);
    put_byte(8'hD5, 1'b0, 1'b0, 1'b0);
    put_byte(8'hA1, 1'b0, 1'b0, 1'b0);
    put_byte(8'hA2, 1'b1, 1'b0, 1'b0);
    #1;
    chk(frame_err == 0, "R3 short preamble bytes not forwarded", frame_err, 0);
    chk(fcs_value == held, "R3 no FCS from short preamble", fcs_value, held);
    @(negedge clk);

    // R4: last inside preamble restarts the hunt
    frame_err = 0;
    for (int i = 0; i < 7; i++) put_byte(8'h55, (i == 6), 1'b0, 1'b0);
    put_byte(8'hD5, 1'b0, 1'b0, 1'b0);
    put_byte(8'h5A, 1'b0, 1'b0, 1'b0);
    put_byte(8'h5B, 1'b1, 1'b0, 1'b0);
    #1;
    chk(frame_err == 0, "R4 aborted hunt forwards nothing", frame_err, 0);
    chk(fcs_value == held, "R4 no FCS after aborted hunt", fcs_value, held);
    @(negedge clk);

    // R2: longer preamble still opens a frame, with stalls
    for (int k = 0; k < 20; k++) body[k] = 8'hC0 + 8'(k * 3);
    run_frame(10, 20, 1'b0, 1'b1, ref_fcs(20), 1'b0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule